// File: doc/BRIEF.md
# Shared Interrupt Link Allocator

This block gives each requesting device one of a small set of shared interrupt links. When a link is handed out for the first time, the block also ties that link to the legal IRQ that carries the lightest load at that moment. It keeps two tables. The first is a use count and a routing register for each link. The second is a load count for each IRQ, and a marker value in that count shows that the IRQ may not be chosen.

Before any allocation takes place, configuration commands can take an IRQ out of the pool (reserve) or add load to it ahead of time (use). An allocation request carries a device slot and an interrupt pin number. In fixed-mapping mode the link comes straight from those two numbers. Otherwise the link is found by a scan for the minimum count. Each scan reads one table entry per clock. The block stays busy until it gives a one-cycle done pulse, which carries the granted link and its IRQ. A new binding also raises a flag asking the system to program that IRQ as level-triggered.

Top module: `irq_link_alloc`

## Requirements
- R1: After reset, busy, done, bind_valid, route_fail and cmd_err are 0. Every link is unrouted, meaning the disable flag is set and the IRQ field is 0. IRQs whose bit is set in PERMIT_MASK (default 16'hDEF8) have load 0, and every other IRQ holds the marker 0xFF.
- R2: When fixed_map is 0, the chosen link is the one with the smallest use count. The scan starts at index 0 and replaces its candidate only on a strictly smaller count, so a tie goes to the lowest index.
- R3: When fixed_map is 1, the chosen link index is (4 + req_slot + req_pin) mod NLINK.
- R4: Every allocation adds one to the use count of the chosen link, whether or not an IRQ gets bound.
- R5: An IRQ is picked only when the chosen link is unrouted. A link that is already routed keeps its IRQ: the done cycle shows bind_valid = 0 and grant_irq equal to the IRQ that link already holds.
- R6: The IRQ scan covers IRQs 0 to NIRQ-1. It skips entries that hold the marker and takes the lowest load, with a tie going to the lowest number. The winner's load goes up by one and the link is routed to it (disable flag cleared). In the done cycle, bind_valid = 1 and bind_irq = grant_irq = winner.
- R7: A reserve command (cmd_op = 0) sets an IRQ's count to the marker, so no later scan picks that IRQ. It is legal when the count is 0 or already holds the marker.
- R8: A use command (cmd_op = 1) adds one to an IRQ's load. It is legal when the count is below marker - 1.
- R9: A command is illegal if it arrives after the first allocation request, while busy, or together with a request, or if it breaks the condition in R7 or R8. An illegal command raises cmd_err for one cycle in the following cycle and changes no state. A legal command leaves cmd_err at 0.
- R10: An allocation request is accepted only when busy is 0. A request raised while busy is dropped and produces no done pulse.
- R11: Each accepted request produces exactly one done pulse, one cycle long, with busy back at 0. grant_link is the chosen link index plus one, in the range 1 to NLINK.
- R12: If the chosen link is unrouted and every IRQ holds the marker, the done cycle shows route_fail = 1 and bind_valid = 0, and the link stays unrouted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request, taken when busy is 0 |
| req_slot | input | SLOT_W | Device slot number |
| req_pin | input | PIN_W | Device interrupt pin number |
| fixed_map | input | 1 | 1: fixed link mapping, 0: least-used scan |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_op | input | 1 | 0 reserve, 1 use |
| cmd_irq | input | $clog2(NIRQ) | IRQ addressed by the command |
| busy | output | 1 | Allocation in progress |
| done | output | 1 | One-cycle completion pulse |
| grant_link | output | $clog2(NLINK)+1 | Granted link, 1-based |
| grant_irq | output | $clog2(NIRQ) | IRQ of the granted link |
| bind_valid | output | 1 | New binding made; level-trigger request for bind_irq |
| bind_irq | output | $clog2(NIRQ) | IRQ just bound |
| route_fail | output | 1 | No legal IRQ was available |
| cmd_err | output | 1 | Previous-cycle command was illegal |

## Verification
A use count that is off by one, or a scan that breaks ties wrongly, first shows up as the wrong grant_link on the next allocation that runs in least-used mode. That is why the bench steps through whole rounds of the links. A corrupted load table or routing register shows up only when a link is newly bound, as the wrong bind_irq, or later as the wrong grant_irq when the same link is granted again. An error in a command's legality shows up at once on cmd_err. A command applied that should have been blocked shows up several allocations later, in which IRQs get picked.

// File: rtl/ila_pkg.sv
package ila_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LSCAN,
    ST_LPICK,
    ST_ISCAN,
    ST_IPICK
  } ila_state_e;

  localparam logic CMD_RESERVE = 1'b0;
  localparam logic CMD_USE     = 1'b1;
endpackage

// File: rtl/ila_min_track.sv
module ila_min_track #(
  parameter int IDX_W = 3,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic [VAL_W-1:0] val,
  input  logic             skip,
  output logic             found,
  output logic [IDX_W-1:0] best_idx
);
  logic [VAL_W-1:0] best_val;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found    <= 1'b0;
      best_idx <= '0;
      best_val <= '0;
    end else if (step && !skip && (!found || val < best_val)) begin
      found    <= 1'b1;
      best_idx <= idx;
      best_val <= val;
    end
  end
endmodule

// File: rtl/ila_link_tab.sv
module ila_link_tab #(
  parameter int NLINK = 8,
  parameter int CNT_W = 8,
  parameter int IRQ_W = 4,
  localparam int LIDX_W = $clog2(NLINK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LIDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [LIDX_W-1:0] sel_idx,
  output logic [IRQ_W:0]    sel_rte,
  input  logic              inc_en,
  input  logic              bind_en,
  input  logic [IRQ_W-1:0]  bind_irq
);
  localparam logic [IRQ_W:0] UNROUTED = {1'b1, {IRQ_W{1'b0}}};

  logic [CNT_W-1:0] use_q [NLINK];
  logic [IRQ_W:0]   rte_q [NLINK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINK; i++) begin
        use_q[i] <= '0;
        rte_q[i] <= UNROUTED;
      end
    end else begin
      if (inc_en)  use_q[sel_idx] <= use_q[sel_idx] + 1'b1;
      if (bind_en) rte_q[sel_idx] <= {1'b0, bind_irq};
    end
  end

  assign rd_cnt  = use_q[rd_idx];
  assign sel_rte = rte_q[sel_idx];
endmodule

// File: rtl/ila_irq_tab.sv
module ila_irq_tab #(
  parameter int              NIRQ        = 16,
  parameter int              CNT_W       = 8,
  parameter logic [NIRQ-1:0] PERMIT_MASK = 16'hDEF8,
  localparam int IIDX_W = $clog2(NIRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IIDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [IIDX_W-1:0] cmd_idx,
  output logic [CNT_W-1:0]  cmd_cnt,
  input  logic              mark_en,
  input  logic [IIDX_W-1:0] mark_idx,
  input  logic              inc_en,
  input  logic [IIDX_W-1:0] inc_idx
);
  localparam logic [CNT_W-1:0] MARK = '1;

  logic [CNT_W-1:0] cnt_w [NIRQ];

  for (genvar g = 0; g < NIRQ; g++) begin : g_ent
    localparam logic [IIDX_W-1:0] MY_IDX = IIDX_W'(g);
    localparam logic [CNT_W-1:0]  RST_V  = PERMIT_MASK[g] ? '0 : MARK;
    logic [CNT_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (rst)                               ent_q <= RST_V;
      else if (mark_en && mark_idx == MY_IDX) ent_q <= MARK;
      else if (inc_en && inc_idx == MY_IDX)   ent_q <= ent_q + 1'b1;
    end
    assign cnt_w[g] = ent_q;
  end

  assign rd_cnt  = cnt_w[rd_idx];
  assign cmd_cnt = cnt_w[cmd_idx];
endmodule

// File: rtl/irq_link_alloc.sv
module irq_link_alloc #(
  parameter int              NLINK       = 8,
  parameter int              NIRQ        = 16,
  parameter int              CNT_W       = 8,
  parameter int              SLOT_W      = 5,
  parameter int              PIN_W       = 3,
  parameter int              FIX_OFS     = 4,
  parameter logic [NIRQ-1:0] PERMIT_MASK = 16'hDEF8,
  localparam int LIDX_W = $clog2(NLINK),
  localparam int IIDX_W = $clog2(NIRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [PIN_W-1:0]  req_pin,
  input  logic              fixed_map,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [IIDX_W-1:0] cmd_irq,
  output logic              busy,
  output logic              done,
  output logic [LIDX_W:0]   grant_link,
  output logic [IIDX_W-1:0] grant_irq,
  output logic              bind_valid,
  output logic [IIDX_W-1:0] bind_irq,
  output logic              route_fail,
  output logic              cmd_err
);
  import ila_pkg::*;

  localparam logic [CNT_W-1:0]  MARK     = '1;
  localparam logic [IIDX_W:0]   UNROUTED = {1'b1, {IIDX_W{1'b0}}};
  localparam int                SUM_W    = (SLOT_W > PIN_W ? SLOT_W : PIN_W) + 4;
  localparam logic [LIDX_W-1:0] LAST_L   = LIDX_W'(NLINK - 1);
  localparam logic [IIDX_W-1:0] LAST_I   = IIDX_W'(NIRQ - 1);

  ila_state_e        state_q;
  logic              cold_q, fixed_q;
  logic [LIDX_W-1:0] lptr_q, link_q, cur_link, sel_idx;
  logic [IIDX_W-1:0] iptr_q;
  logic [SUM_W-1:0]  fix_sum;
  logic [LIDX_W-1:0] fix_link;

  logic [CNT_W-1:0]  l_rd_cnt, i_rd_cnt, i_cmd_cnt;
  logic [IIDX_W:0]   sel_rte;
  logic              l_found, i_found;
  logic [LIDX_W-1:0] l_best;
  logic [IIDX_W-1:0] i_best;
  logic              l_clear, i_clear, l_step, i_step;
  logic              cmd_ok, mark_en, inc_en, l_inc, l_bind;
  logic [IIDX_W-1:0] inc_idx;

  assign fix_sum  = SUM_W'(FIX_OFS) + SUM_W'(req_slot) + SUM_W'(req_pin);
  assign fix_link = LIDX_W'(fix_sum % SUM_W'(NLINK));
  assign cur_link = fixed_q ? link_q : l_best;
  assign sel_idx  = (state_q == ST_LPICK) ? cur_link : link_q;

  always_comb begin
    cmd_ok = 1'b0;
    if (cold_q && state_q == ST_IDLE && !req_valid) begin
      if (cmd_op == CMD_USE) cmd_ok = (i_cmd_cnt < MARK - 1'b1);
      else                   cmd_ok = (i_cmd_cnt == '0) || (i_cmd_cnt == MARK);
    end
  end

  assign l_clear = (state_q == ST_IDLE) && req_valid;
  assign l_step  = (state_q == ST_LSCAN);
  assign i_clear = (state_q == ST_LPICK);
  assign i_step  = (state_q == ST_ISCAN);
  assign l_inc   = (state_q == ST_LPICK);
  assign l_bind  = (state_q == ST_IPICK) && i_found;
  assign mark_en = cmd_valid && cmd_ok && (cmd_op == CMD_RESERVE);
  assign inc_en  = (cmd_valid && cmd_ok && (cmd_op == CMD_USE)) || l_bind;
  assign inc_idx = l_bind ? i_best : cmd_irq;
  assign busy    = (state_q != ST_IDLE);

  ila_min_track #(.IDX_W(LIDX_W), .VAL_W(CNT_W)) u_ltrk (
    .clk(clk), .rst(rst), .clear(l_clear), .step(l_step),
    .idx(lptr_q), .val(l_rd_cnt), .skip(1'b0),
    .found(l_found), .best_idx(l_best)
  );

  ila_min_track #(.IDX_W(IIDX_W), .VAL_W(CNT_W)) u_itrk (
    .clk(clk), .rst(rst), .clear(i_clear), .step(i_step),
    .idx(iptr_q), .val(i_rd_cnt), .skip(i_rd_cnt == MARK),
    .found(i_found), .best_idx(i_best)
  );

  ila_link_tab #(.NLINK(NLINK), .CNT_W(CNT_W), .IRQ_W(IIDX_W)) u_ltab (
    .clk(clk), .rst(rst), .rd_idx(lptr_q), .rd_cnt(l_rd_cnt),
    .sel_idx(sel_idx), .sel_rte(sel_rte), .inc_en(l_inc),
    .bind_en(l_bind), .bind_irq(i_best)
  );

  ila_irq_tab #(.NIRQ(NIRQ), .CNT_W(CNT_W), .PERMIT_MASK(PERMIT_MASK)) u_itab (
    .clk(clk), .rst(rst), .rd_idx(iptr_q), .rd_cnt(i_rd_cnt),
    .cmd_idx(cmd_irq), .cmd_cnt(i_cmd_cnt), .mark_en(mark_en),
    .mark_idx(cmd_irq), .inc_en(inc_en), .inc_idx(inc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cold_q     <= 1'b1;
      fixed_q    <= 1'b0;
      lptr_q     <= '0;
      iptr_q     <= '0;
      link_q     <= '0;
      done       <= 1'b0;
      grant_link <= '0;
      grant_irq  <= '0;
      bind_valid <= 1'b0;
      bind_irq   <= '0;
      route_fail <= 1'b0;
      cmd_err    <= 1'b0;
    end else begin
      done       <= 1'b0;
      bind_valid <= 1'b0;
      route_fail <= 1'b0;
      cmd_err    <= cmd_valid && !cmd_ok;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cold_q  <= 1'b0;
            fixed_q <= fixed_map;
            lptr_q  <= '0;
            link_q  <= fix_link;
            state_q <= fixed_map ? ST_LPICK : ST_LSCAN;
          end
        end
        ST_LSCAN: begin
          lptr_q <= lptr_q + 1'b1;
          if (lptr_q == LAST_L) state_q <= ST_LPICK;
        end
        ST_LPICK: begin
          link_q <= cur_link;
          iptr_q <= '0;
          if (sel_rte == UNROUTED) begin
            state_q <= ST_ISCAN;
          end else begin
            done       <= 1'b1;
            grant_link <= {1'b0, cur_link} + 1'b1;
            grant_irq  <= sel_rte[IIDX_W-1:0];
            state_q    <= ST_IDLE;
          end
        end
        ST_ISCAN: begin
          iptr_q <= iptr_q + 1'b1;
          if (iptr_q == LAST_I) state_q <= ST_IPICK;
        end
        ST_IPICK: begin
          done       <= 1'b1;
          grant_link <= {1'b0, link_q} + 1'b1;
          grant_irq  <= i_found ? i_best : '0;
          bind_valid <= i_found;
          bind_irq   <= i_best;
          route_fail <= !i_found;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ila_chk.sv
module ila_chk #(
  parameter int NLINK = 8,
  parameter int NIRQ  = 16,
  localparam int LIDX_W = $clog2(NLINK),
  localparam int IIDX_W = $clog2(NIRQ)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic [LIDX_W:0]   grant_link,
  input logic [IIDX_W-1:0] grant_irq,
  input logic              bind_valid,
  input logic [IIDX_W-1:0] bind_irq,
  input logic              route_fail,
  input logic              cmd_err
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r11_grant_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (grant_link >= 1 && grant_link <= (LIDX_W+1)'(NLINK)));
  a_r10_start_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  a_r6_bind_consistent: assert property (@(posedge clk) disable iff (rst)
    bind_valid |-> (done && !route_fail && grant_irq == bind_irq));
  a_r12_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    route_fail |-> (done && !bind_valid));
  a_r9_err_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid));
endmodule

bind irq_link_alloc ila_chk #(.NLINK(NLINK), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .cmd_valid(cmd_valid),
  .busy(busy), .done(done), .grant_link(grant_link), .grant_irq(grant_irq),
  .bind_valid(bind_valid), .bind_irq(bind_irq), .route_fail(route_fail),
  .cmd_err(cmd_err)
);

// File: tb/tb_irq_link_alloc.sv
module tb_irq_link_alloc;
  localparam logic [15:0] MASK = 16'hDEF8;

  logic       clk = 0, rst = 1;
  logic       req_valid = 0, fixed_map = 0, cmd_valid = 0, cmd_op = 0;
  logic [4:0] req_slot = 0;
  logic [2:0] req_pin = 0;
  logic [3:0] cmd_irq = 0;
  logic       busy, done, bind_valid, route_fail, cmd_err;
  logic [3:0] grant_link, grant_irq, bind_irq;

  irq_link_alloc dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_slot(req_slot),
    .req_pin(req_pin), .fixed_map(fixed_map), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_irq(cmd_irq), .busy(busy), .done(done),
    .grant_link(grant_link), .grant_irq(grant_irq), .bind_valid(bind_valid),
    .bind_irq(bind_irq), .route_fail(route_fail), .cmd_err(cmd_err)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit ended = 0;
  int m_lcnt [8];
  logic [4:0] m_lrte [8];
  int m_icnt [16];
  bit m_cold;
  logic [9:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_lcnt[i] = 0; m_lrte[i] = 5'h10; end
    for (int i = 0; i < 16; i++) m_icnt[i] = MASK[i] ? 0 : 255;
    m_cold = 1;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    @(negedge clk);
    check(busy == 0 && done == 0 && bind_valid == 0 && route_fail == 0 && cmd_err == 0,
          "R1 reset outputs", {busy, done, bind_valid, route_fail, cmd_err}, 0);
  endtask

  // scoreboard item: {link[3:0], irq[3:0], bind, fail}
  task automatic push_expect(input int slot, input int pin, input bit fx, input string tag);
    int l, b;
    bit bnd, fl;
    logic [3:0] irq;
    m_cold = 0;
    if (fx) l = (4 + slot + pin) % 8;
    else begin
      l = 0;
      for (int i = 1; i < 8; i++) if (m_lcnt[i] < m_lcnt[l]) l = i;
    end
    m_lcnt[l]++;
    bnd = 0; fl = 0;
    if (m_lrte[l] == 5'h10) begin
      b = -1;
      for (int i = 0; i < 16; i++)
        if (m_icnt[i] != 255 && (b < 0 || m_icnt[i] < m_icnt[b])) b = i;
      if (b < 0) begin fl = 1; irq = 0; end
      else begin
        m_icnt[b]++; m_lrte[l] = {1'b0, 4'(b)}; bnd = 1; irq = 4'(b);
      end
    end else irq = m_lrte[l][3:0];
    exp_q.push_back({4'(l + 1), irq, bnd, fl});
    tag_q.push_back(tag);
  endtask

  task automatic do_alloc(input int slot, input int pin, input bit fx, input string tag,
                          input bit poke);
    push_expect(slot, pin, fx, tag);
    @(negedge clk);
    req_valid = 1; req_slot = 5'(slot); req_pin = 3'(pin); fixed_map = fx;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      check(busy == 1, "R10 busy while scanning", busy, 1);
      req_valid = 1; req_slot = 5'd3; req_pin = 3'd2; fixed_map = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input bit op, input int irq, input string tag);
    bit legal;
    if (op) legal = m_cold && m_icnt[irq] < 254;
    else    legal = m_cold && (m_icnt[irq] == 0 || m_icnt[irq] == 255);
    if (legal) begin
      if (op) m_icnt[irq]++; else m_icnt[irq] = 255;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_irq = 4'(irq);
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_err == !legal, tag, cmd_err, !legal);
  endtask

  // monitor: compare each done pulse against the head of the queue
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected done", grant_link, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(grant_link == e[9:6], {t, " R11 link"}, grant_link, e[9:6]);
        check(grant_irq == e[5:2], {t, " irq"}, grant_irq, e[5:2]);
        check(bind_valid == e[1], {t, " R6 bind flag"}, bind_valid, e[1]);
        check(route_fail == e[0], {t, " R12 fail flag"}, route_fail, e[0]);
        if (e[1]) check(bind_irq == e[5:2], {t, " R6 bind irq"}, bind_irq, e[5:2]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // configuration commands before any allocation
    do_cmd(0, 3, "R7 reserve free IRQ");
    do_cmd(0, 0, "R7 reserve marked IRQ");
    do_cmd(1, 4, "R8 use IRQ");
    do_cmd(1, 5, "R8 use IRQ");
    do_cmd(1, 5, "R8 use IRQ again");
    do_cmd(1, 3, "R9 use reserved IRQ");
    do_cmd(0, 4, "R9 reserve loaded IRQ");
    // least-used rounds: links 1..8 then wrap (R2, R4, R6, R5)
    for (int i = 0; i < 8; i++) do_alloc(i, 1, 0, "R2 R6 first round", i == 2);
    do_alloc(0, 1, 0, "R4 R5 wrap to link 1", 0);
    do_alloc(0, 1, 0, "R4 R5 wrap to link 2", 1);
    do_cmd(1, 6, "R9 use after allocation");
    do_cmd(0, 7, "R9 reserve after allocation");
    check(exp_q.size() == 0, "R10 R11 queue drained", exp_q.size(), 0);

    // fixed mapping from a fresh reset (R3, R1 lowest legal IRQ)
    do_reset();
    do_alloc(0, 1, 1, "R3 R1 slot0 pin1", 0);
    do_alloc(7, 2, 1, "R3 R5 same link", 0);
    do_alloc(31, 4, 1, "R3 slot31 pin4", 1);
    do_alloc(0, 0, 0, "R2 R4 least-used after fixed", 0);
    do_alloc(0, 0, 0, "R2 R4 next least-used", 0);

    // no legal IRQ left (R12)
    do_reset();
    for (int i = 0; i < 16; i++) if (MASK[i]) do_cmd(0, i, "R7 reserve all");
    do_alloc(0, 0, 0, "R12 no IRQ link 1", 0);
    do_alloc(0, 0, 0, "R12 no IRQ link 2", 0);
    do_alloc(4, 0, 1, "R12 R4 fixed revisit", 0);
    check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule